// File: doc/BRIEF.md
# Greyscale Scan-Out Pixel Expander

The block walks a framebuffer of packed 4-bit grey levels, two pixels per byte, and turns it into a stream of colour pixels for a display pipeline. Each grey level is widened to the selected colour format by repeating its own bits. Every source pixel is sent several times in a row, and every source line is sent several times over, so a small image scales up by a whole factor in both directions. With the default geometry of 64 lines of 64 bytes and a factor of four, one frame is 512 by 256 pixels.

A frame only begins after a redraw request has been latched. The block reads the framebuffer one byte at a time through a synchronous read port that has one cycle of latency. It sends the pixels on a valid/ready output, marking the first pixel of each output line and the first pixel of each frame. When the consumer accepts the final pixel, the block raises a one-cycle completion pulse and clears the pending request. The display timing generator and any row or column remapping sit outside this block.

Top module: `grey_scanout`

## Requirements
- R1: After a synchronous reset, `pix_valid`, `frame_done` and `fb_rd_en` are all low.
- R2: While no redraw request is pending, the block issues no framebuffer reads and keeps `pix_valid` low.
- R3: Inside each byte, the high nibble (bits 7:4) is the left pixel and the low nibble (bits 3:0) the right pixel. Each of the two is emitted SCALE times back to back.
- R4: Each output line covers bytes 0 to BYTES-1 of one source line, read from address `line*BYTES + col`. Each source line is emitted SCALE times before the next one, for source lines 0 to LINES-1 in order. `pix_sol` is high on the first pixel of every output line and low on every other pixel.
- R5: `pix_sof` is high on the first pixel of a frame and low on every other pixel.
- R6: With `pix_fmt` = 0 (15-bit), the level is n = 2*i + (i>>3) for grey value i. The output is `pix_data` = n<<10 | n<<5 | n, with bits 23:15 zero.
- R7: With `pix_fmt` = 1 (16-bit), red and blue take n and green takes the 6-bit value g = (n<<1) | (n>>4). The output is `pix_data` = n<<11 | g<<5 | n, with bits 23:16 zero.
- R8: With `pix_fmt` = 2 or 3 (24-bit), each of the three bytes of `pix_data` is (i<<4) | i.
- R9: While `pix_valid` is high and `pix_ready` is low, the next cycle still has `pix_valid` high, with `pix_data`, `pix_sol` and `pix_sof` unchanged.
- R10: `frame_done` is high for exactly one cycle, the cycle after the last pixel of the frame is accepted. The pending request is then clear, so no further pixels follow unless `redraw_req` is asserted again. A request that arrives in the same cycle as that final acceptance starts another frame.
- R11: Read data is taken in the cycle after `fb_rd_en`. Per frame there are exactly BYTES*LINES*SCALE reads, one each time a line pass moves to a byte, and two reads are never issued in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redraw_req | input | 1 | Pulse that makes a frame pending |
| pix_fmt | input | 2 | 0: 15-bit, 1: 16-bit, 2 or 3: 24-bit |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_rd_addr | output | AW | Framebuffer byte address |
| fb_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_data | output | 24 | Colour pixel, zero-extended for the narrow formats |
| pix_sol | output | 1 | First pixel of an output line |
| pix_sof | output | 1 | First pixel of a frame |
| frame_done | output | 1 | One-cycle pulse after the last pixel is accepted |

## Verification
The bench builds the block with BYTES=3, LINES=2 and SCALE=2, which gives a 48-pixel frame. At that size, full frames in every format and under several ready patterns run in a few hundred cycles, and the line-repeat and frame-wrap boundaries come up in every frame. The odd byte count puts a non-power-of-two stride through the address arithmetic. Because SCALE is 2, a nibble-boundary or line-repeat miscount shows up directly in the pixel order.

// File: rtl/grey_scanout_pkg.sv
package grey_scanout_pkg;

  typedef enum logic [1:0] {
    FMT_555  = 2'd0,
    FMT_565  = 2'd1,
    FMT_888  = 2'd2,
    FMT_888X = 2'd3
  } pix_fmt_e;

  // Widen a 4-bit grey level by bit replication into the chosen format.
  function automatic logic [23:0] grey_expand(pix_fmt_e f, logic [3:0] v);
    logic [4:0] lv;
    logic [7:0] b8;
    lv = {v, v[3]};
    b8 = {v, v};
    case (f)
      FMT_555: grey_expand = {8'h00, 1'b0, lv, lv, lv};
      FMT_565: grey_expand = {8'h00, lv, lv, lv[4], lv};
      default: grey_expand = {b8, b8, b8};
    endcase
  endfunction

endpackage

// File: rtl/grey_conv.sv
module grey_conv
  import grey_scanout_pkg::*;
(
  input  logic [1:0]  fmt,
  input  logic [3:0]  level,
  output logic [23:0] colour
);
  always_comb colour = grey_expand(pix_fmt_e'(fmt), level);
endmodule

// File: rtl/grey_scan.sv
module grey_scan #(
  parameter int BYTES = 64,
  parameter int LINES = 64,
  parameter int SCALE = 4,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          adv,
  input  logic          acc,
  input  logic [7:0]    rd_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          run,
  output logic          tail,
  output logic [3:0]    level,
  output logic          sol,
  output logic          sof
);
  localparam int SUBN = 2 * SCALE;
  localparam int SUBW = $clog2(SUBN);
  localparam int BXW  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int RYW  = (SCALE > 1) ? $clog2(SCALE) : 1;
  localparam int YW   = (LINES > 1) ? $clog2(LINES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_e;
  st_e st;

  logic [SUBW-1:0] sub;
  logic [BXW-1:0]  bx, n_bx;
  logic [RYW-1:0]  ry;
  logic [YW-1:0]   y, n_y;
  logic            last_sub, last_bx, last_ry, last_y, last_pix;
  logic            load_q;
  logic [7:0]      byte_q, cur_byte;

  assign last_sub = int'(sub) == SUBN - 1;
  assign last_bx  = int'(bx) == BYTES - 1;
  assign last_ry  = int'(ry) == SCALE - 1;
  assign last_y   = int'(y) == LINES - 1;
  assign last_pix = last_sub && last_bx && last_ry && last_y;

  // Position of the byte that follows the current one.
  always_comb begin
    n_bx = last_bx ? '0 : bx + 1'b1;
    n_y  = y;
    if (last_bx && last_ry) n_y = last_y ? '0 : y + 1'b1;
  end

  assign run  = st == S_RUN;
  assign tail = st == S_TAIL;

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    if (st == S_IDLE && go) begin
      rd_en = 1'b1;
    end else if (run && adv && last_sub && !last_pix) begin
      rd_en   = 1'b1;
      rd_addr = AW'(n_y) * AW'(BYTES) + AW'(n_bx);
    end
  end

  // Fresh read data is used directly in the cycle it arrives.
  assign cur_byte = load_q ? rd_data : byte_q;
  assign level    = (int'(sub) < SCALE) ? cur_byte[7:4] : cur_byte[3:0];
  assign sol      = (sub == '0) && (bx == '0);
  assign sof      = sol && (ry == '0) && (y == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      sub    <= '0;
      bx     <= '0;
      ry     <= '0;
      y      <= '0;
      load_q <= 1'b0;
      byte_q <= '0;
    end else begin
      load_q <= rd_en;
      if (load_q) byte_q <= rd_data;
      case (st)
        S_IDLE: if (go) st <= S_RUN;
        S_RUN: if (adv) begin
          if (!last_sub) begin
            sub <= sub + 1'b1;
          end else begin
            sub <= '0;
            bx  <= n_bx;
            y   <= n_y;
            if (last_bx) ry <= last_ry ? '0 : ry + 1'b1;
          end
          if (last_pix) st <= S_TAIL;
        end
        S_TAIL: if (acc) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: one read per byte, so two strobes never come back to back.
  p_read_gap_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  // R2: nothing is read while the scan is idle and no frame is pending.
  p_idle_noread_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !go) |-> !rd_en);

endmodule

// File: rtl/grey_scanout.sv
module grey_scanout #(
  parameter int BYTES = 64,
  parameter int LINES = 64,
  parameter int SCALE = 4,
  localparam int AW   = (BYTES * LINES > 1) ? $clog2(BYTES * LINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redraw_req,
  input  logic [1:0]    pix_fmt,
  output logic          fb_rd_en,
  output logic [AW-1:0] fb_rd_addr,
  input  logic [7:0]    fb_rd_data,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [23:0]   pix_data,
  output logic          pix_sol,
  output logic          pix_sof,
  output logic          frame_done
);
  logic        pending, run, tail, adv, sol, sof;
  logic [3:0]  level;
  logic [23:0] colour;

  assign adv = run && (!pix_valid || pix_ready);

  grey_scan #(.BYTES(BYTES), .LINES(LINES), .SCALE(SCALE), .AW(AW)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .go      (pending),
    .adv     (adv),
    .acc     (pix_ready),
    .rd_data (fb_rd_data),
    .rd_en   (fb_rd_en),
    .rd_addr (fb_rd_addr),
    .run     (run),
    .tail    (tail),
    .level   (level),
    .sol     (sol),
    .sof     (sof)
  );

  grey_conv u_conv (
    .fmt    (pix_fmt),
    .level  (level),
    .colour (colour)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      frame_done <= 1'b0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      pix_sol    <= 1'b0;
      pix_sof    <= 1'b0;
    end else begin
      // A new request wins over the clear at the end of a frame.
      pending    <= redraw_req | (pending & ~(tail & pix_ready));
      frame_done <= tail & pix_ready;
      if (adv) begin
        pix_valid <= 1'b1;
        pix_data  <= colour;
        pix_sol   <= sol;
        pix_sof   <= sof;
      end else if (pix_ready) begin
        pix_valid <= 1'b0;
      end
    end
  end

  // R9: a stalled pixel is held unchanged.
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) &&
                                   $stable(pix_sol) && $stable(pix_sof)));

  // R10: completion is a single-cycle pulse.
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R10: completion follows the final acceptance, so the output is drained.
  p_done_drained_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !pix_valid);

  // R5: a frame start is always also a line start.
  p_sof_on_sol_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_sof) |-> pix_sol);

endmodule

// File: tb/sim_grey_scanout.sv
module sim_grey_scanout;
  localparam int B = 3;
  localparam int L = 2;
  localparam int S = 2;
  localparam int AW = $clog2(B * L);
  localparam int TOTAL = 2 * S * B * S * L;
  localparam int READS = B * L * S;

  // Stimulus table: {rearm, fmt[1:0], ready mask[7:0]}
  localparam int NCFG = 6;
  localparam logic [10:0] CFG [NCFG] = '{
    {1'b0, 2'd0, 8'hFF},
    {1'b0, 2'd1, 8'hFF},
    {1'b0, 2'd2, 8'hFF},
    {1'b0, 2'd3, 8'h5A},
    {1'b0, 2'd1, 8'h93},
    {1'b1, 2'd0, 8'hC3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic redraw_req = 1'b0;
  logic [1:0] pix_fmt = 2'd0;
  logic fb_rd_en;
  logic [AW-1:0] fb_rd_addr;
  logic [7:0] fb_rd_data = 8'h00;
  logic pix_valid;
  logic pix_ready = 1'b0;
  logic [23:0] pix_data;
  logic pix_sol, pix_sof, frame_done;

  logic [7:0] fb [B * L];
  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;

  always #10 clk = ~clk;

  grey_scanout #(.BYTES(B), .LINES(L), .SCALE(S)) u0 (
    .clk(clk), .rst(rst), .redraw_req(redraw_req), .pix_fmt(pix_fmt),
    .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_sol(pix_sol), .pix_sof(pix_sof), .frame_done(frame_done)
  );

  always @(posedge clk) if (fb_rd_en) fb_rd_data <= fb[int'(fb_rd_addr)];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_pix(input logic [1:0] f, input int i);
    int n, g, p;
    n = 2 * i + (i >> 3);
    g = (n << 1) | (n >> 4);
    p = (i << 4) | i;
    case (f)
      2'd0: ref_pix = 24'((n << 10) | (n << 5) | n);
      2'd1: ref_pix = 24'((n << 11) | (g << 5) | n);
      default: ref_pix = 24'((p << 16) | (p << 8) | p);
    endcase
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'd0: fmt_tag = "R3 R6";
      2'd1: fmt_tag = "R3 R7";
      default: fmt_tag = "R3 R8";
    endcase
  endfunction

  task automatic run_frame(input logic [1:0] f, input logic [7:0] mask, input bit rearm);
    int got = 0;
    int cyc = 0;
    logic pv = 1'b0;
    logic pr = 1'b0;
    logic [23:0] pp = '0;
    logic [1:0] psm = '0;
    while (got < TOTAL && cyc < 3000) begin
      @(negedge clk);
      pix_ready = mask[cyc % 8];
      #1;
      redraw_req = (rearm && got == TOTAL - 1 && pix_valid && pix_ready);
      if (fb_rd_en) rd_cnt++;
      if (pv && !pr)
        chk("R9 stall hold", {7'd0, pix_valid, pix_data},
            {7'd0, 1'b1, pp});
      if (pv && !pr)
        chk("R9 marker hold", {30'd0, pix_sol, pix_sof}, {30'd0, psm});
      if (pix_valid && pix_ready) begin
        int sub, bx, ry, y, nib;
        logic [7:0] by;
        sub = got % (2 * S);
        bx  = (got / (2 * S)) % B;
        ry  = (got / (2 * S * B)) % S;
        y   = got / (2 * S * B * S);
        by  = fb[y * B + bx];
        nib = (sub < S) ? int'(by[7:4]) : int'(by[3:0]);
        chk(fmt_tag(f), {8'd0, pix_data}, {8'd0, ref_pix(f, nib)});
        chk("R4 R5 markers", {30'd0, pix_sol, pix_sof},
            {30'd0, (sub == 0 && bx == 0), (sub == 0 && bx == 0 && ry == 0 && y == 0)});
        chk("R10 no early done", {31'd0, frame_done}, 32'd0);
        got++;
      end
      pv = pix_valid; pr = pix_ready; pp = pix_data; psm = {pix_sol, pix_sof};
      cyc++;
    end
    chk("R10 frame length", got, TOTAL);
    chk("R11 read count", rd_cnt, READS);
    @(negedge clk);
    redraw_req = 1'b0;
    #1;
    rd_cnt = fb_rd_en ? 1 : 0;
    chk("R10 done pulse", {30'd0, frame_done, pix_valid}, {30'd0, 1'b1, 1'b0});
    @(negedge clk);
    #1;
    if (fb_rd_en) rd_cnt++;
    chk("R10 done width", {31'd0, frame_done}, 32'd0);
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_ready = 1'b1;
      #1;
      if (pix_valid || fb_rd_en) seen++;
    end
    chk(req, seen, 0);
  endtask

  initial begin
    for (int a = 0; a < B * L; a++) fb[a] = 8'(a * 59 + 30);
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset outputs", {29'd0, pix_valid, frame_done, fb_rd_en}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 after release", {29'd0, pix_valid, frame_done, fb_rd_en}, 32'd0);
    quiet(20, "R2 idle without request");

    for (int e = 0; e < NCFG; e++) begin
      logic [10:0] c;
      c = CFG[e];
      pix_fmt = c[9:8];
      @(negedge clk);
      rd_cnt = 0;
      redraw_req = 1'b1;
      run_frame(c[9:8], c[7:0], c[10]);
      if (c[10]) begin
        // R10: request in the final-accept cycle starts one more frame
        run_frame(c[9:8], 8'hFF, 1'b0);
      end
      quiet(12, "R10 pending cleared");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule